// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC deframer and decides whether the address field of each received frame matches the programmed station address. The deframer has already removed flags and bit stuffing. It delivers whole octets with a byte-valid strobe, and it marks the frame boundaries with a start strobe and an end strobe. Each frame gets one verdict: match or mismatch. Downstream logic uses a mismatch to discard the frame's data.

A 2-bit mode input picks the comparison:

| Mode | Comparison |
|------|------------|
| 00 | None (every frame matches) |
| 01 | First octet against the high address |
| 10 | First octet against the low address |
| 11 | First octet against the high address, then the second octet against the low address |

In the high-address comparison, bit 1 of the octet is the command/response bit and is ignored. The two broadcast-style values 0xFC and 0xFE are accepted in addition to the programmed high address. The low-address comparison uses all eight bits. The mode is captured at frame start and applies to the whole frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, verdict_vld_o and match_o are both 0.
- R2: In mode 00, the cycle after frame start shows verdict_vld_o=1 and match_o=1, whatever octets follow.
- R3: In mode 01, the cycle after the first octet is accepted shows verdict_vld_o=1. match_o is 1 exactly when (octet | 0x02) equals (high_addr_i | 0x02) or equals 0xFE.
- R4: In mode 01, the first octets 0xFC and 0xFE always give match_o=1.
- R5: In mode 10, the cycle after the first octet shows verdict_vld_o=1. match_o is 1 exactly when the octet equals low_addr_i on all 8 bits.
- R6: In mode 11, the first octet is judged as in R3, and the second octet must equal low_addr_i. The verdict appears the cycle after the second octet.
- R7: With mode not 00, a frame that ends before its required octets gives verdict_vld_o=1 and match_o=0 the cycle after the end strobe. An octet accepted in the same cycle as the end strobe still counts.
- R8: Once verdict_vld_o is 1, the verdict holds until the next frame start. Octets after the deciding one, and octets between frames, have no effect.
- R9: An octet valid in the same cycle as frame start is the first address octet of the new frame. The mode is sampled at frame start, and later changes to mode_i within the frame have no effect.
- R10: With mode not 00, verdict_vld_o is 0 from the cycle after frame start until the deciding octet or the end of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Frame start strobe |
| oct_vld_i | input | 1 | Octet valid strobe |
| oct_i | input | 8 | Received octet |
| eof_i | input | 1 | Frame end strobe |
| mode_i | input | 2 | Comparison mode (00 off, 01 high, 10 low, 11 both) |
| high_addr_i | input | 8 | Programmed high address |
| low_addr_i | input | 8 | Programmed low address |
| verdict_vld_o | output | 1 | Verdict available for the current frame |
| match_o | output | 1 | 1 = address match, 0 = mismatch |

## Verification
Two events can land in the same cycle. The frame start can coincide with the first address octet, and the end strobe can coincide with the deciding octet. The bench provokes the first case by raising the octet strobe together with frame start on alternate frames of the low-mode sweep. It provokes the second by raising the end strobe on the last octet. In both cases the verdict must equal the arithmetic expectation computed from the octets, just as it does when the strobes arrive in separate cycles.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  localparam int unsigned OCT_W = 8;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_BOTH = 2'b11
  } af_mode_e;
endpackage

// File: rtl/hdlc_af_cmp.sv
module hdlc_af_cmp #(
  parameter int unsigned OCT_W     = 8,
  parameter int unsigned CR_BIT    = 1,
  parameter int unsigned NUM_FIXED = 2,
  parameter logic [NUM_FIXED*OCT_W-1:0] FIXED_ADDRS = {8'hFE, 8'hFC}
) (
  input  logic [OCT_W-1:0] oct_i,
  input  logic [OCT_W-1:0] high_addr_i,
  input  logic [OCT_W-1:0] low_addr_i,
  output logic             hi_ok_o,
  output logic             lo_ok_o
);
  localparam logic [OCT_W-1:0] CR_MASK = OCT_W'(1) << CR_BIT;

  logic [OCT_W-1:0]   oct_m;
  logic [NUM_FIXED:0] hit;

  assign oct_m  = oct_i | CR_MASK;
  assign hit[0] = (oct_m == (high_addr_i | CR_MASK));

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
    assign hit[g+1] = (oct_m == (FIXED_ADDRS[g*OCT_W +: OCT_W] | CR_MASK));
  end

  assign hi_ok_o = |hit;
  assign lo_ok_o = (oct_i == low_addr_i);
endmodule

// File: rtl/hdlc_af_verdict.sv
module hdlc_af_verdict
  import hdlc_af_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sof_i,
  input  logic     oct_vld_i,
  input  logic     eof_i,
  input  af_mode_e mode_i,
  input  logic     hi_ok_i,
  input  logic     lo_ok_i,
  output logic     done_o,
  output logic     match_o
);
  af_mode_e mode_q, eff_mode;
  logic active_q, sec_q, hi_q, done_q, match_q;
  logic eff_act, eff_done, eff_match, eff_sec;
  logic n_act, n_sec, n_hi, n_done, n_match;

  always_comb begin
    eff_mode  = sof_i ? mode_i : mode_q;
    eff_act   = sof_i | active_q;
    eff_done  = sof_i ? (mode_i == MODE_OFF) : done_q;
    eff_match = sof_i ? (mode_i == MODE_OFF) : match_q;
    eff_sec   = sof_i ? 1'b0 : sec_q;
    n_done    = eff_done;
    n_match   = eff_match;
    n_sec     = eff_sec;
    n_hi      = hi_q;
    if (eff_act && oct_vld_i && !eff_done) begin
      unique case (eff_mode)
        MODE_HIGH: begin n_done = 1'b1; n_match = hi_ok_i; end
        MODE_LOW:  begin n_done = 1'b1; n_match = lo_ok_i; end
        MODE_BOTH: begin
          if (!eff_sec) begin
            n_sec = 1'b1;
            n_hi  = hi_ok_i;
          end else begin
            n_done  = 1'b1;
            n_match = hi_q & lo_ok_i;
          end
        end
        default: ;
      endcase
    end
    // short frame: missing address octets count as a mismatch
    if (eff_act && eof_i && !n_done) begin
      n_done  = 1'b1;
      n_match = 1'b0;
    end
    n_act = eff_act & ~eof_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_OFF;
      active_q <= 1'b0;
      sec_q    <= 1'b0;
      hi_q     <= 1'b0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      mode_q   <= eff_mode;
      active_q <= n_act;
      sec_q    <= n_sec;
      hi_q     <= n_hi;
      done_q   <= n_done;
      match_q  <= n_match;
    end
  end

  assign done_o  = done_q;
  assign match_o = match_q;

  a_r2_off_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && mode_i == MODE_OFF |=> done_o && match_o);
  a_r10_clear_on_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i && mode_i != MODE_OFF && !oct_vld_i && !eof_i |=> !done_o);
  a_r7_eof_decides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_i && (sof_i || active_q) |=> done_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !sof_i |=> done_o && $stable(match_o));
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !sof_i |=> $stable(done_o) && $stable(match_o));
  a_r3_match_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o);
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             oct_vld_i,
  input  logic [OCT_W-1:0] oct_i,
  input  logic             eof_i,
  input  logic [1:0]       mode_i,
  input  logic [OCT_W-1:0] high_addr_i,
  input  logic [OCT_W-1:0] low_addr_i,
  output logic             verdict_vld_o,
  output logic             match_o
);
  logic hi_ok, lo_ok;

  hdlc_af_cmp #(
    .OCT_W (OCT_W),
    .CR_BIT(1)
  ) u_cmp (
    .oct_i      (oct_i),
    .high_addr_i(high_addr_i),
    .low_addr_i (low_addr_i),
    .hi_ok_o    (hi_ok),
    .lo_ok_o    (lo_ok)
  );

  hdlc_af_verdict u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sof_i    (sof_i),
    .oct_vld_i(oct_vld_i),
    .eof_i    (eof_i),
    .mode_i   (af_mode_e'(mode_i)),
    .hi_ok_i  (hi_ok),
    .lo_ok_i  (lo_ok),
    .done_o   (verdict_vld_o),
    .match_o  (match_o)
  );
endmodule

// File: tb/hdlc_addr_filter_test.sv
module hdlc_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, vld = 1'b0, eof = 1'b0;
  logic [7:0] oct = 8'h00;
  logic [1:0] mode = 2'b00;
  logic [7:0] hadr = 8'h40, ladr = 8'hA5;
  logic       vv, mt;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  hdlc_addr_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .oct_vld_i(vld), .oct_i(oct),
    .eof_i(eof), .mode_i(mode), .high_addr_i(hadr), .low_addr_i(ladr),
    .verdict_vld_o(vv), .match_o(mt)
  );

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if ({vv, mt} !== exp) begin
      errors++;
      $display("FAIL %s: {vld,match}=%b expected %b", req, {vv, mt}, exp);
    end
  endtask

  function automatic bit hi_exp(input logic [7:0] b);
    return ((b | 8'h02) == (hadr | 8'h02)) || ((b | 8'h02) == 8'hFE);
  endfunction

  task automatic run_frame(input logic [1:0] m, input int nb, input logic [7:0] b0,
                           input logic [7:0] b1, input bit on_sof, input bit eof_last,
                           input string req);
    logic [7:0] bytes [3];
    bit exp;
    int k;
    bytes = '{b0, b1, ~b0};
    case (m)
      2'b00: exp = 1'b1;
      2'b01: exp = (nb >= 1) && hi_exp(b0);
      2'b10: exp = (nb >= 1) && (b0 == ladr);
      default: exp = (nb >= 2) && hi_exp(b0) && (b1 == ladr);
    endcase
    k = 0;
    @(negedge clk);
    sof = 1'b1; mode = m;
    if (on_sof && nb > 0) begin
      oct = bytes[0]; vld = 1'b1; eof = eof_last && nb == 1; k = 1;
    end
    @(negedge clk);
    sof = 1'b0; vld = 1'b0; eof = 1'b0; mode = ~m;  // R9: mid-frame mode change
    if (m != 2'b00 && k == 0) check("R10", 2'b00);
    for (int i = k; i < nb; i++) begin
      oct = bytes[i]; vld = 1'b1; eof = eof_last && (i == nb - 1);
      @(negedge clk);
      vld = 1'b0; eof = 1'b0;
    end
    if (!(eof_last && nb > 0)) begin
      eof = 1'b1;
      @(negedge clk);
      eof = 1'b0;
    end
    check(req, {1'b1, exp});
    oct = ~b1; vld = 1'b1;  // R8: stray octet between frames
    @(negedge clk);
    vld = 1'b0;
    check("R8", {1'b1, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00);
    // R2: no comparison
    run_frame(2'b00, 0, 8'h00, 8'h00, 0, 0, "R2");
    run_frame(2'b00, 2, 8'h13, 8'h77, 1, 1, "R2");
    // R3/R4: high byte sweep
    for (int b = 0; b < 256; b++)
      run_frame(2'b01, 1, 8'(b), 8'h00, 0, 1,
                ((8'(b) | 8'h02) == 8'hFE) ? "R4" : "R3");
    // R5/R9: low byte sweep, alternating octet on frame start
    for (int b = 0; b < 256; b++)
      run_frame(2'b10, 2, 8'(b), 8'h00, b[0], 0, b[0] ? "R9" : "R5");
    // R6/R7: both bytes, second octet sweep
    for (int j = 0; j < 5; j++) begin
      logic [7:0] f;
      case (j)
        0: f = hadr; 1: f = 8'hFC; 2: f = 8'hFE; 3: f = hadr ^ 8'h02;
        default: f = 8'h41 ^ 8'h80;
      endcase
      for (int b = 0; b < 256; b++)
        run_frame(2'b11, 3, f, 8'(b), 0, b[1], b[1] ? "R7" : "R6");
    end
    // R7: frames ending early
    run_frame(2'b01, 0, hadr, ladr, 0, 0, "R7");
    run_frame(2'b10, 0, ladr, ladr, 0, 0, "R7");
    run_frame(2'b11, 0, hadr, ladr, 0, 0, "R7");
    run_frame(2'b11, 1, hadr, ladr, 0, 1, "R7");
    run_frame(2'b11, 1, hadr, ladr, 1, 1, "R7");
    // different high address
    hadr = 8'h02;
    for (int b = 0; b < 8; b++)
      run_frame(2'b01, 1, 8'(b), 8'h00, 1, 1, "R3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule